// File: doc/BRIEF.md
# Selectable Pseudorandom Pattern Generator

This block is the sending side of a bit error rate tester. Each strobe on `step` makes it produce one serial pattern bit. The bit is taken from one of five pseudorandom sequences, and the output can be inverted if required. The block does not switch to a new sequence just because the select input changes. A host picks a sequence on `pat_sel` and then raises `load`. That rising edge reseeds the shift register to all ones and commits the selection. The register then moves forward one step for each strobe.

One sequence mode is a 2^20−1 sequence with a zero-run limit. In this mode a bit is forced to 1 whenever the fourteen bits sent just before it were all zero. The shift register itself keeps advancing normally, so the next raw bit is unaffected. A load with a select code that has no sequence parks the block in a silent state: the output stays 0 and no valid strobes appear.

The controller has three states:
- `ST_IDLE`: the state after reset, before any load.
- `ST_RUN`: a supported sequence has been loaded.
- `ST_HALT`: an unsupported code has been loaded.

Every state has the same two exits:
- `load` rising with a supported `pat_sel` goes to `ST_RUN`.
- `load` rising with an unsupported `pat_sel` goes to `ST_HALT`.
- Without a load edge, the state is kept.

Top module: `prbs_gen_tx`

## Requirements
- R1: After reset, `bit_out` and `bit_vld` are 0. Strobes on `step` produce no valid bit until a load edge occurs.
- R2: A 0-to-1 transition of `load` commits `pat_sel`, seeds the register with all ones and clears both outputs in the following cycle. The sequence then restarts from its first bit, and a second load mid-run restarts it again.
- R3: Holding `load` high does not reload. `load` must return to 0 before another edge counts, and the sequence continues across the held-high period.
- R4: Changing `pat_sel` without a load edge leaves the running sequence unchanged.
- R5: With history bits s[k-1], s[k-2] and so on, all initialised to 1 by the load, each new bit is s[k] = s[k-a] xor s[k-b]. The select codes give: 000 → (a=7, b=6); 001 → (11, 9); 010 → (15, 14); 111 → (9, 5).
- R6: Code 011 uses (a=20, b=17). If the 14 previously emitted bits (taken before inversion) were all 0, the emitted bit is forced to 1. The recurrence history still takes the unforced value, so no more than 14 consecutive zeros are ever emitted.
- R7: When `tx_inv`, sampled with the strobe, is 1, the emitted bit is inverted. When it is 0, the bit is passed unchanged.
- R8: After a load with code 100, 101 or 110, `bit_out` stays 0 and `bit_vld` stays 0 regardless of `step`.
- R9: In `ST_RUN`, a strobe on `step` in one cycle gives `bit_vld` = 1 and the new `bit_out` in the next cycle. Without a strobe, `bit_vld` is 0 and `bit_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Advance strobe, one bit per cycle held high |
| load | input | 1 | Load control, acts on its rising edge |
| pat_sel | input | 3 | Sequence select code |
| tx_inv | input | 1 | Output inversion enable |
| bit_out | output | 1 | Serial pattern bit |
| bit_vld | output | 1 | Pulses for one cycle with each new bit |

## Verification
The assertions rely on three assumptions about the inputs:
- `load` and `step` are single-bit levels sampled on the clock edge.
- A load edge and a strobe in the same cycle resolve in favour of the load.
- The shift register can only leave its seed through strobes made while in `ST_RUN`.

The stimulus keeps to these assumptions. It changes every input at the falling edge and never relies on a strobe coinciding with a load edge. It also holds `tx_inv` and `pat_sel` steady within each stretch of strobes, except where R4 changes `pat_sel` on purpose.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
    localparam int unsigned PRBS_W  = 20;
    localparam int unsigned PRBS_IW = $clog2(PRBS_W);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HALT} gen_state_t;

    localparam logic [2:0] SEL_P7   = 3'b000;
    localparam logic [2:0] SEL_P11  = 3'b001;
    localparam logic [2:0] SEL_P15  = 3'b010;
    localparam logic [2:0] SEL_QRSS = 3'b011;
    localparam logic [2:0] SEL_P9   = 3'b111;

    function automatic logic sel_supported(input logic [2:0] s);
        return (s == SEL_P7) || (s == SEL_P11) || (s == SEL_P15) ||
               (s == SEL_QRSS) || (s == SEL_P9);
    endfunction

    // index of the oldest history bit used (degree - 1)
    function automatic logic [PRBS_IW-1:0] sel_hi(input logic [2:0] s);
        case (s)
            SEL_P7:   return PRBS_IW'(6);
            SEL_P9:   return PRBS_IW'(8);
            SEL_P11:  return PRBS_IW'(10);
            SEL_P15:  return PRBS_IW'(14);
            SEL_QRSS: return PRBS_IW'(19);
            default:  return '0;
        endcase
    endfunction

    // index of the inner feedback tap (tap - 1)
    function automatic logic [PRBS_IW-1:0] sel_tp(input logic [2:0] s);
        case (s)
            SEL_P7:   return PRBS_IW'(5);
            SEL_P9:   return PRBS_IW'(4);
            SEL_P11:  return PRBS_IW'(8);
            SEL_P15:  return PRBS_IW'(13);
            SEL_QRSS: return PRBS_IW'(16);
            default:  return '0;
        endcase
    endfunction
endpackage

// File: rtl/prbs_edge_det.sv
module prbs_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_in;
    end

    assign rise = sig_in && !sig_q;

    AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise) else $error("load edge seen twice in a row"); // R3
endmodule

// File: rtl/prbs_lfsr.sv
module prbs_lfsr
    import prbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed,
    input  logic       adv,
    input  logic [2:0] mode,
    output logic       fb
);
    logic [PRBS_W-1:0]  r;
    logic [PRBS_W-1:0]  live_mask;
    logic [PRBS_IW-1:0] hi_idx, tp_idx;

    assign hi_idx = sel_hi(mode);
    assign tp_idx = sel_tp(mode);
    assign fb     = r[hi_idx] ^ r[tp_idx];

    always_ff @(posedge clk) begin
        if (!rst_n || seed) r <= '1;
        else if (adv)       r <= {r[PRBS_W-2:0], fb};
    end

    // bits that belong to the active recurrence
    for (genvar i = 0; i < PRBS_W; i++) begin : g_mask
        assign live_mask[i] = (PRBS_IW'(i) <= hi_idx);
    end

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (r & live_mask) != '0) else $error("register locked at zero"); // R2
    AST_SEED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> (r == '1)) else $error("seed not all ones"); // R2
endmodule

// File: rtl/prbs_zero_guard.sv
module prbs_zero_guard #(
    parameter int unsigned ZERO_LIMIT = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic qrss,
    input  logic raw,
    output logic guarded
);
    localparam int unsigned CW = $clog2(ZERO_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(ZERO_LIMIT);

    logic [CW-1:0] zcnt;

    assign guarded = raw || (qrss && (zcnt == LIM));

    always_ff @(posedge clk) begin
        if (!rst_n || clr)  zcnt <= '0;
        else if (adv) begin
            if (guarded)            zcnt <= '0;
            else if (zcnt != LIM)   zcnt <= zcnt + 1'b1;
        end
    end

    AST_ZERO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        zcnt <= LIM) else $error("zero run counter overflow"); // R6
    AST_RUN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (qrss && adv && zcnt == LIM) |=> (zcnt == '0)) else $error("zero run not broken"); // R6
endmodule

// File: rtl/prbs_gen_tx.sv
module prbs_gen_tx
    import prbs_pkg::*;
#(
    parameter int unsigned ZERO_LIMIT = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       load,
    input  logic [2:0] pat_sel,
    input  logic       tx_inv,
    output logic       bit_out,
    output logic       bit_vld
);
    gen_state_t state_q, state_d;
    logic [2:0] mode_q;
    logic       load_rise, adv, raw_bit, guard_bit, is_qrss;

    prbs_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (load),
        .rise   (load_rise)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_rise) state_d = sel_supported(pat_sel) ? ST_RUN : ST_HALT;
            ST_RUN:  if (load_rise) state_d = sel_supported(pat_sel) ? ST_RUN : ST_HALT;
            ST_HALT: if (load_rise) state_d = sel_supported(pat_sel) ? ST_RUN : ST_HALT;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register with committed mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= SEL_P7;
        end else begin
            state_q <= state_d;
            if (load_rise) mode_q <= pat_sel;
        end
    end

    assign adv     = step && (state_q == ST_RUN) && !load_rise;
    assign is_qrss = (mode_q == SEL_QRSS);

    prbs_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (load_rise),
        .adv   (adv),
        .mode  (mode_q),
        .fb    (raw_bit)
    );

    prbs_zero_guard #(.ZERO_LIMIT(ZERO_LIMIT)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load_rise),
        .adv     (adv),
        .qrss    (is_qrss),
        .raw     (raw_bit),
        .guarded (guard_bit)
    );

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n || load_rise) begin
            bit_out <= 1'b0;
            bit_vld <= 1'b0;
        end else if (adv) begin
            bit_out <= guard_bit ^ tx_inv;
            bit_vld <= 1'b1;
        end else begin
            bit_vld <= 1'b0;
        end
    end

    AST_VLD_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $past(step)) else $error("valid without strobe"); // R9
    AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!adv && !load_rise) |-> $stable(bit_out)) else $error("bit moved without strobe"); // R9
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        load_rise |=> (!bit_vld && !bit_out)) else $error("load did not clear outputs"); // R2
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> (!bit_vld && !bit_out)) else $error("halt state emitting"); // R8
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !bit_vld) else $error("idle state emitting"); // R1
endmodule

// File: tb/prbs_gen_tx_test.sv
`timescale 1ns/1ps
module prbs_gen_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, step = 1'b0, load = 1'b0, tx_inv = 1'b0;
    logic [2:0] pat_sel = 3'b000;
    logic       bit_out, bit_vld;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [19:0] h;
    logic [2:0]  msel;
    int          zrun, maxrun;
    logic        last_exp;

    // {sel, inv, count}
    localparam int NV = 7;
    localparam logic [23:0] VEC [NV] = '{
        {3'b000, 1'b0, 20'd300},
        {3'b111, 1'b0, 20'd1100},
        {3'b001, 1'b1, 20'd2100},
        {3'b010, 1'b0, 20'd3000},
        {3'b011, 1'b0, 20'd120000},
        {3'b000, 1'b1, 20'd200},
        {3'b111, 1'b1, 20'd600}
    };

    prbs_gen_tx uut (
        .clk(clk), .rst_n(rst_n), .step(step), .load(load),
        .pat_sel(pat_sel), .tx_inv(tx_inv), .bit_out(bit_out), .bit_vld(bit_vld)
    );

    always #2.5 clk = ~clk;

    function automatic int deg_of(input logic [2:0] s);
        case (s)
            3'b000: return 7;  3'b001: return 11; 3'b010: return 15;
            3'b011: return 20; 3'b111: return 9;  default: return 0;
        endcase
    endfunction

    function automatic int tap_of(input logic [2:0] s);
        case (s)
            3'b000: return 6;  3'b001: return 9;  3'b010: return 14;
            3'b011: return 17; 3'b111: return 5;  default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_next(output logic nb);
        logic raw;
        raw = 1'((h >> (deg_of(msel) - 1)) ^ (h >> (tap_of(msel) - 1)));
        h = {h[18:0], raw};
        nb = raw;
        if (msel == 3'b011 && zrun >= 14) nb = 1'b1;
        zrun = nb ? 0 : zrun + 1;
        if (zrun > maxrun) maxrun = zrun;
    endtask

    task automatic do_load(input logic [2:0] sel);
        @(negedge clk);
        pat_sel = sel;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        msel = sel; h = '1; zrun = 0; maxrun = 0;
        chk(bit_vld == 1'b0 && bit_out == 1'b0, "R2", 32'({bit_vld, bit_out}), 32'd0);
    endtask

    task automatic run_steps(input int n, input string req);
        logic e;
        step = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (deg_of(msel) != 0) begin
                model_next(e);
                e = e ^ tx_inv;
                last_exp = e;
                chk(bit_vld == 1'b1 && bit_out == e, req, 32'({bit_vld, bit_out}), 32'({1'b1, e}));
            end else begin
                chk(bit_vld == 1'b0 && bit_out == 1'b0, req, 32'({bit_vld, bit_out}), 32'd0);
            end
        end
        step = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        msel = 3'b000; h = '1; zrun = 0; maxrun = 0; last_exp = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state and no output before any load
        chk(bit_vld == 1'b0 && bit_out == 1'b0, "R1", 32'({bit_vld, bit_out}), 32'd0);
        rst_n = 1'b1;
        step = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(bit_vld == 1'b0 && bit_out == 1'b0, "R1", 32'({bit_vld, bit_out}), 32'd0);
        end
        step = 1'b0;

        // table walk: R5 sequences, R6 zero limit, R7 inversion
        for (int v = 0; v < NV; v++) begin
            logic [2:0] s;
            logic       iv;
            s  = VEC[v][23:21];
            iv = VEC[v][20];
            tx_inv = iv;
            do_load(s);
            run_steps(int'(VEC[v][19:0]), (s == 3'b011) ? "R6" : (iv ? "R7" : "R5"));
            if (s == 3'b011)
                chk(maxrun <= 14, "R6", 32'(maxrun), 32'd14);
        end
        tx_inv = 1'b0;

        // R2: reload mid-run restarts the sequence
        do_load(3'b000);
        run_steps(15, "R2");
        do_load(3'b000);
        run_steps(15, "R2");

        // R3: held-high load does not reload
        @(negedge clk);
        pat_sel = 3'b001; load = 1'b1;
        @(negedge clk);
        msel = 3'b001; h = '1; zrun = 0;
        run_steps(25, "R3");
        run_steps(25, "R3");
        load = 1'b0;
        run_steps(10, "R3");

        // R4: select change without load has no effect
        do_load(3'b010);
        run_steps(10, "R4");
        pat_sel = 3'b111;
        run_steps(40, "R4");

        // R9: no strobe -> no valid, bit holds
        repeat (3) begin
            @(negedge clk);
            chk(bit_vld == 1'b0 && bit_out == last_exp, "R9", 32'({bit_vld, bit_out}), 32'({1'b0, last_exp}));
        end

        // R8: unsupported codes stay silent
        do_load(3'b100);
        run_steps(6, "R8");
        do_load(3'b101);
        tx_inv = 1'b1;
        run_steps(6, "R8");
        do_load(3'b110);
        run_steps(6, "R8");
        tx_inv = 1'b0;

        // recovery from halt
        do_load(3'b111);
        run_steps(50, "R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule